// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Core

This block models a single-ported synchronous static memory. It has a registered, two-stage read path and writes that complete within the cycle that captures them. Every address, control and write-data input is sampled on the rising clock edge. An access begins when either of two address strobes loads an external address and captures the chip-enable state at the same time. A 2-bit counter then produces the rest of a four-beat burst. It steps only on the cycles that assert the advance input, in linear or interleaved order, and the upper address bits do not change during the burst.

The word is divided into lanes of 9 bits. A write can update any subset of lanes: per-lane write strobes take effect when a lane gate is low, and a global write updates every lane. Three chip enables together select the device, so several banks can share one data bus. Read data becomes valid after the second rising edge following the access. The drive indication is gated without a clock by an output enable, and it goes low one cycle after a deselect. A sleep input stops all activity and drops the selection.

Top module: `sram_burst_core`

## Requirements
- R1: After a synchronous reset the device is deselected, and `q_drive_o` stays 0 until a read is issued.
- R2: A read issued at rising edge E (a load or a burst beat while selected, with no write qualified) places the word on `q_o` after edge E+1, and `q_drive_o` is 1 from then on while `oe_n` is low.
- R3: When both strobes are low in one cycle, the processor strobe wins. A cycle loaded by the processor strobe is always a read, whatever the write controls are.
- R4: The processor strobe is ignored while `sel0_n` is high, and that cycle then behaves as a controller-strobe load or as a burst continuation.
- R5: With `lin_order`=1 the burst address low bits are (base+k) mod 4, where k counts the cycles with `adv_n` low since the load. Upper bits stay fixed, and k holds while `adv_n` is high.
- R6: With `lin_order`=0 the burst address low bits are base XOR k.
- R7: When `lane_gate_n` is low, `lane_we_n[i]`=0 writes bits [9i+8:9i] only. When `lane_gate_n` is high, the per-lane strobes write nothing.
- R8: `wr_all_n`=0 writes all lanes, whatever `lane_gate_n` and `lane_we_n` are.
- R9: A load selects the device only if `sel0_n`=0, `sel1`=1 and `sel2_n`=0. While deselected no access occurs, and the drive from an earlier read ends one cycle after the deselecting edge.
- R10: `q_drive_o` follows `oe_n` without waiting for a clock edge.
- R11: A cycle with `sleep_i` high performs no access, ignores both strobes and deselects the device until the next load.
- R12: After four advances the burst counter wraps and the base address repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External word address |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel0_n | input | 1 | Chip enable, active low |
| sel1 | input | 1 | Chip enable, active high |
| sel2_n | input | 1 | Chip enable, active low |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| lane_gate_n | input | 1 | Enables the per-lane strobes, active low |
| wr_all_n | input | 1 | Global all-lane write, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep_i | input | 1 | Sleep: no access, deselect |
| oe_n | input | 1 | Output enable, active low, not clocked |
| q_o | output | LANES*LANE_W | Registered read data |
| q_drive_o | output | 1 | Data bus drive indication |

## Verification
A wrong burst counter or wrong order logic shows up two edges later as a wrong word on `q_o` during an interleaved or linear sweep started from every base address. A lane mask that is off by one shows up only on a later read of that address, as a foreign or stale 9-bit field. A selection bit that is kept wrongly, or a sleep that does not clear it, shows up as `q_drive_o` high on a cycle where no drive is expected, or as data that a continuation write should not have changed. Every cycle the drive indication and the data are compared with a bench model that is two stages behind.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low two address bits for beat 'step' of a burst starting at 'base'
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input logic       lin);
    logic [1:0] r;
    if (lin) r = base + step;
    else     r = base ^ step;
    return r;
  endfunction

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              lane_gate_n,
  input  logic              wr_all_n,
  input  logic              lin_order,
  input  logic              sleep_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  lane_wr_o,
  output logic              rd_o
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q, hi_nx;
  logic [1:0]      base_q, base_nx, cnt_q, cnt_nx;
  logic            sel_q, act;
  logic            cpu_go, ctl_go, load, en_now;
  logic [LANES-1:0] qual;
  op_e             op;

  for (genvar g = 0; g < LANES; g++) begin : g_qual
    assign qual[g] = !wr_all_n || (!lane_gate_n && !lane_we_n[g]);
  end

  always_comb begin
    cpu_go  = !strb_cpu_n && !sel0_n && !sleep_i;
    ctl_go  = !strb_ctl_n && !cpu_go && !sleep_i;
    load    = cpu_go || ctl_go;
    en_now  = !sel0_n && sel1 && !sel2_n;
    if (sleep_i)   act = 1'b0;
    else if (load) act = en_now;
    else           act = sel_q;
    hi_nx   = load ? addr_i[ADDR_W-1:2] : hi_q;
    base_nx = load ? addr_i[1:0] : base_q;
    if (load)                     cnt_nx = 2'd0;
    else if (!adv_n && !sleep_i)  cnt_nx = cnt_q + 2'd1;
    else                          cnt_nx = cnt_q;
    if (!act)                     op = OP_NONE;
    else if (!cpu_go && |qual)    op = OP_WRITE;
    else                          op = OP_READ;
  end

  assign mem_addr_o = {hi_nx, burst_low(base_nx, cnt_nx, lin_order)};
  assign lane_wr_o  = (op == OP_WRITE) ? qual : '0;
  assign rd_o       = (op == OP_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else begin
      hi_q   <= hi_nx;
      base_q <= base_nx;
      cnt_q  <= cnt_nx;
      sel_q  <= act;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == 2'd0 && base_q == $past(addr_i[1:0])));
  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n && !sleep_i) |=> (cnt_q == $past(cnt_q) + 2'd1));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && (adv_n || sleep_i)) |=> ($stable(cnt_q) && $stable(hi_q)));
  assert_cpu_read_R3: assert property (@(posedge clk) disable iff (rst)
    (!strb_cpu_n && !sel0_n && !sleep_i) |-> (lane_wr_o == '0));
  assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    sleep_i |-> (!rd_o && lane_wr_o == '0));

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        lane_wr_i,
  input  logic                    rd_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (lane_wr_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      if (rd_i)         rd_q        <= mem[addr_i];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/sram_out_pipe.sv
module sram_out_pipe #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              oe_n,
  output logic [DATA_W-1:0] q_o,
  output logic              valid_o,
  output logic              drive_o
);
  logic              rd1_q, valid_q;
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd1_q   <= 1'b0;
      valid_q <= 1'b0;
      q_q     <= '0;
    end else begin
      rd1_q   <= rd_i;
      valid_q <= rd1_q;
      if (rd1_q) q_q <= data_i;
    end
  end

  assign q_o     = q_q;
  assign valid_o = valid_q;
  assign drive_o = valid_q && !oe_n;

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd1_q |=> $stable(q_q));
  assert_valid_src_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(rd_i, 2));

endmodule

// File: rtl/sram_burst_core.sv
module sram_burst_core #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    adv_n,
  input  logic                    sel0_n,
  input  logic                    sel1,
  input  logic                    sel2_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    lane_gate_n,
  input  logic                    wr_all_n,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    lin_order,
  input  logic                    sleep_i,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] q_o,
  output logic                    q_drive_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] mem_addr;
  logic [LANES-1:0]  lane_wr;
  logic              rd_issue, q_valid;
  logic [DATA_W-1:0] bank_q;

  sram_burst_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) seq_i (
    .clk(clk), .rst(rst), .addr_i(addr_i),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .lane_we_n(lane_we_n), .lane_gate_n(lane_gate_n), .wr_all_n(wr_all_n),
    .lin_order(lin_order), .sleep_i(sleep_i),
    .mem_addr_o(mem_addr), .lane_wr_o(lane_wr), .rd_o(rd_issue)
  );

  sram_lane_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) bank_i (
    .clk(clk), .addr_i(mem_addr), .lane_wr_i(lane_wr), .rd_i(rd_issue),
    .wdata_i(wdata_i), .rdata_o(bank_q)
  );

  sram_out_pipe #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst(rst), .rd_i(rd_issue), .data_i(bank_q), .oe_n(oe_n),
    .q_o(q_o), .valid_o(q_valid), .drive_o(q_drive_o)
  );

  assert_sleep_drop_R11: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> ##1 !q_valid);
  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !q_drive_o);
  assert_one_op_R2: assert property (@(posedge clk) disable iff (rst)
    !(rd_issue && (lane_wr != '0)));

endmodule

// File: tb/sram_burst_core_tb.sv
module sram_burst_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] addr_i;
  logic strb_cpu_n, strb_ctl_n, adv_n, sel0_n, sel1, sel2_n;
  logic [NL-1:0] lane_we_n;
  logic lane_gate_n, wr_all_n, lin_order, sleep_i, oe_n;
  logic [DW-1:0] wdata_i, q_o;
  logic q_drive_o;

  int checks = 0;
  int fails = 0;

  logic [DW-1:0] mem_m [DEPTH];
  int  m_hi, m_base, m_cnt;
  bit  m_sel;
  bit  p1v, p2v;
  logic [DW-1:0] p1d, p2d;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_burst_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
    .clk(clk), .rst(rst), .addr_i(addr_i),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .lane_we_n(lane_we_n), .lane_gate_n(lane_gate_n), .wr_all_n(wr_all_n),
    .wdata_i(wdata_i), .lin_order(lin_order), .sleep_i(sleep_i), .oe_n(oe_n),
    .q_o(q_o), .q_drive_o(q_drive_o)
  );

  function automatic logic [DW-1:0] dat(input int a);
    logic [DW-1:0] r;
    r = DW'(a) * 36'd2654435 + 36'h3_0F0F_1234;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
    sel0_n = 0; sel1 = 1; sel2_n = 0;
    lane_we_n = '1; lane_gate_n = 1; wr_all_n = 1; sleep_i = 0; oe_n = 0;
  endtask

  // one clock with the currently driven inputs; the model follows the requirements
  task automatic step(input string tag);
    bit cpu, ctl, ld, en, act, wr;
    int lo, a;
    logic [NL-1:0] msk;
    bit nv;
    logic [DW-1:0] nd;
    cpu = !strb_cpu_n && !sel0_n && !sleep_i;          // R3 R4 R11
    ctl = !strb_ctl_n && !cpu && !sleep_i;
    ld  = cpu || ctl;
    en  = !sel0_n && sel1 && !sel2_n;                  // R9
    act = sleep_i ? 0 : (ld ? en : m_sel);
    if (ld) begin m_hi = int'(addr_i) / 4; m_base = int'(addr_i) % 4; m_cnt = 0; end
    else if (!adv_n && !sleep_i) m_cnt = (m_cnt + 1) % 4;   // R12 wrap
    lo = lin_order ? (m_base + m_cnt) % 4 : (m_base ^ m_cnt); // R5 R6
    a  = m_hi * 4 + lo;
    for (int i = 0; i < NL; i++) msk[i] = !wr_all_n || (!lane_gate_n && !lane_we_n[i]); // R7 R8
    wr = act && !cpu && (msk != '0);
    nv = act && !wr;
    nd = mem_m[a];
    if (wr) for (int i = 0; i < NL; i++) if (msk[i]) mem_m[a][i*LW +: LW] = wdata_i[i*LW +: LW];
    m_sel = act;
    @(posedge clk); @(negedge clk);
    p2v = p1v; p2d = p1d; p1v = nv; p1d = nd;
    chk(q_drive_o == (p2v && !oe_n), tag, DW'(q_drive_o), DW'(p2v && !oe_n));
    if (p2v && !oe_n) chk(q_o == p2d, tag, q_o, p2d);
  endtask

  task automatic deselect();
    idle(); strb_ctl_n = 0; sel1 = 0; step("R9");
    idle(); step("R9"); step("R9");
  endtask

  task automatic read_at(input int a, input string tag);
    idle(); strb_cpu_n = 0; addr_i = AW'(a); step(tag);
    idle(); step(tag);
    deselect();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle(); addr_i = '0; wdata_i = '0; lin_order = 1; rst = 1;
    m_hi = 0; m_base = 0; m_cnt = 0; m_sel = 0; p1v = 0; p2v = 0; p1d = '0; p2d = '0;
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: quiet after reset
    for (int i = 0; i < 3; i++) step("R1");

    // fill every word through linear controller-strobe bursts with global write (R8, R5)
    // with lane_gate_n high and the lane strobes idle
    lin_order = 1;
    for (int g = 0; g < DEPTH/4; g++) begin
      idle(); strb_ctl_n = 0; wr_all_n = 0; addr_i = AW'(g*4); wdata_i = dat(g*4); step("R8");
      for (int k = 1; k < 4; k++) begin
        idle(); adv_n = 0; wr_all_n = 0; wdata_i = dat(g*4 + k); step("R8");
      end
    end
    deselect();

    // R6 and R2: interleaved burst from every base address
    lin_order = 0;
    for (int b = 0; b < DEPTH; b++) begin
      idle(); strb_cpu_n = 0; addr_i = AW'(b); step("R6");
      for (int k = 0; k < 3; k++) begin idle(); adv_n = 0; step("R6"); end
    end
    deselect();

    // R5 and R12: linear bursts with holds and a wrap
    lin_order = 1;
    for (int b = 0; b < DEPTH; b += 5) begin
      idle(); strb_cpu_n = 0; addr_i = AW'(b); step("R5");
      idle(); adv_n = 0; step("R5");
      idle(); step("R5");
      for (int k = 0; k < 4; k++) begin idle(); adv_n = 0; step("R12"); end
    end
    deselect();

    // R7: every lane mask through the gated per-lane strobes
    for (int m = 0; m < (1 << NL); m++) begin
      idle(); strb_ctl_n = 0; addr_i = AW'(5); lane_gate_n = 0; lane_we_n = ~NL'(m);
      wdata_i = dat(m + 100); step("R7");
      deselect();
      read_at(5, "R7");
    end
    // R7: lane strobes with the gate high write nothing
    idle(); strb_ctl_n = 0; addr_i = AW'(5); lane_we_n = '0; wdata_i = dat(999); step("R7");
    deselect(); read_at(5, "R7");
    // R8: global write overrides a closed gate
    idle(); strb_ctl_n = 0; addr_i = AW'(6); wr_all_n = 0; lane_gate_n = 1; wdata_i = dat(777); step("R8");
    deselect(); read_at(6, "R8");

    // R3: both strobes low with a global write pending -> a read, nothing written
    idle(); strb_cpu_n = 0; strb_ctl_n = 0; addr_i = AW'(9); wr_all_n = 0; wdata_i = dat(555); step("R3");
    idle(); step("R3");
    deselect(); read_at(9, "R3");

    // R4: processor strobe with sel0_n high is ignored; the burst continues
    idle(); strb_cpu_n = 0; addr_i = AW'(12); step("R4");
    idle(); strb_cpu_n = 0; sel0_n = 1; addr_i = AW'(40); step("R4");
    idle(); strb_cpu_n = 0; sel0_n = 1; adv_n = 0; addr_i = AW'(41); step("R4");
    idle(); step("R4"); step("R4");
    deselect();

    // R9: deselected loads, then continuation writes that must not land
    idle(); strb_cpu_n = 0; addr_i = AW'(20); step("R9");
    idle(); strb_ctl_n = 0; sel2_n = 1; addr_i = AW'(21); step("R9");
    idle(); wr_all_n = 0; wdata_i = dat(321); step("R9");
    idle(); adv_n = 0; wr_all_n = 0; wdata_i = dat(322); step("R9");
    read_at(21, "R9"); read_at(22, "R9");

    // R10: output enable gates the drive between edges
    idle(); strb_cpu_n = 0; addr_i = AW'(30); step("R10");
    idle(); step("R10"); step("R10");
    oe_n = 1; #1;
    chk(q_drive_o == 1'b0, "R10", DW'(q_drive_o), DW'(0));
    oe_n = 0; #1;
    chk(q_drive_o == 1'b1, "R10", DW'(q_drive_o), DW'(1));
    step("R10");
    deselect();

    // R11: sleep ignores strobes and writes, then leaves the device deselected
    idle(); strb_cpu_n = 0; addr_i = AW'(33); step("R11");
    idle(); sleep_i = 1; strb_ctl_n = 0; wr_all_n = 0; addr_i = AW'(34); wdata_i = dat(444); step("R11");
    idle(); step("R11");
    idle(); wr_all_n = 0; wdata_i = dat(445); step("R11");
    step("R11");
    read_at(33, "R11"); read_at(34, "R11");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule